// File: doc/BRIEF.md
# Configurable Product-Term Logic Cell

This block is one logic cell of a programmable fabric, modelled at the register-transfer level. Eighteen logic inputs and their complements form a literal set; a programmable AND array turns these literals into product terms; OR sums, an optional XOR stage, an optional D register and a polarity select then produce four outputs. Each output picks between a narrow four-term path that skips the wide sum and the full twenty-term sum with its XOR stage. Three further product terms act as a register clear, as a register clock source, and as an exported output-enable for a neighbouring I/O cell.

All programming goes through a parallel write port (`cfg_we`, `cfg_addr`, `cfg_data`). Addresses 0 to 22 hold the 36-bit literal mask of one product term each. Addresses 24 to 27 hold the 24-bit mode word of outputs 0 to 3. Address 28 bit 0 selects the register clock source. The configuration is not cleared by reset; it persists until rewritten. The logic path is combinational from `lin` to `dout` and `oe_out`, except for outputs placed in registered mode.

Top module: `ptl_block`

## Requirements
- R1: Product term j is the AND of the literals enabled in its mask; mask bit 2i enables input i, bit 2i+1 enables the complement of input i; a term with no literal enabled is 0.
- R2: In bypass mode (mode bit 20) output k takes the OR of product terms 4k to 4k+3, and its 20-bit term mask (mode bits 19:0) has no effect.
- R3: Outside bypass mode with the XOR stage off, output k takes the OR of every term among 0..19 whose mask bit is set.
- R4: With the XOR stage on (mode bit 21), output k takes the OR of its masked terms with term 16+k left out, XORed with term 16+k.
- R5: The polarity bit (mode bit 23) inverts output k after every other stage, including the register.
- R6: With the register select (mode bit 22) set, output k shows a D register that loads the logic value at a capturing clock edge, so a change at the inputs shows one edge later; with it clear the output follows the logic without delay.
- R7: `rst_n` low at a rising `clk` edge clears all four registers, and it takes priority over everything else.
- R8: When product term 20 is 1 at a rising edge, all four registers clear instead of loading.
- R9: With address 28 bit 0 set, registers load only at edges where product term 21 is 1 and was 0 at the previous edge (taken as 0 just after reset); with it clear they load at every edge.
- R10: `oe_out` equals product term 22 combinationally.
- R11: A write stores `cfg_data` at `cfg_addr` at a rising edge when `cfg_we` is 1; with `cfg_we` 0 the configuration is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock; all registers use its rising edge |
| rst_n | input | 1 | Synchronous active-low clear of the output registers |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word address |
| cfg_data | input | 36 | Configuration word; mode words use bits 23:0 |
| lin | input | 18 | Logic inputs |
| dout | output | 4 | Cell outputs, one bit per output |
| oe_out | output | 1 | Output-enable product term, exported |

## Verification
The embedded assertions watch every clock cycle for the register behaviour: a capturing edge loads the logic value, a non-capturing edge holds the state, the clear term empties the registers, a rising clock term captures when the term clock is chosen, and configuration writes land only when strobed. The combinational functions (literal decoding, bypass against wide path, the XOR split, polarity, the exported enable) and the effect of the reset state on inverted outputs can only be shown by the bench, which drives a hand-computed vector table, directed corner cases and random configurations checked against its own model.

// File: rtl/ptl_pkg.sv
// Package: sizes, address map and mode-word layout shared by the
// product-term logic cell and its bench. Assumes NSUM >= XOR_BASE + NOUT.
package ptl_pkg;
    localparam int NIN       = 18;
    localparam int NLIT      = 2 * NIN;
    localparam int NOUT      = 4;
    localparam int NBYP      = 4;
    localparam int XOR_BASE  = NOUT * NBYP;
    localparam int NSUM      = XOR_BASE + NOUT;
    localparam int PT_RST    = NSUM;
    localparam int PT_CLK    = NSUM + 1;
    localparam int PT_OE     = NSUM + 2;
    localparam int NPT       = NSUM + 3;
    localparam int OCFG_BASE = NPT + 1;
    localparam int CLKSEL_AD = OCFG_BASE + NOUT;
    localparam int AW        = $clog2(CLKSEL_AD + 1);
    localparam int DW        = NLIT;
    localparam int OCW       = NSUM + 4;

    typedef struct packed {
        logic            invert;
        logic            reg_sel;
        logic            xor_en;
        logic            bypass;
        logic [NSUM-1:0] mask;
    } ocfg_t;
endpackage

// File: rtl/ptl_cfg_store.sv
// Configuration storage. Holds one literal mask per product term, one
// mode word per output and the clock-source select. Not cleared by reset:
// the contents persist until overwritten through the write port.
module ptl_cfg_store
    import ptl_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [AW-1:0]             cfg_addr,
    input  logic [DW-1:0]             cfg_data,
    output logic [NPT-1:0][NLIT-1:0]  lit_mask,
    output ocfg_t [NOUT-1:0]          ocfg,
    output logic                      clk_sel_pt
);

    // Decode the address and store the strobed word.
    always_ff @(posedge clk) begin
        if (cfg_we) begin
            for (int j = 0; j < NPT; j++) begin
                if (cfg_addr == AW'(j)) lit_mask[j] <= cfg_data;
            end
            for (int k = 0; k < NOUT; k++) begin
                if (cfg_addr == AW'(OCFG_BASE + k)) ocfg[k] <= ocfg_t'(cfg_data[OCW-1:0]);
            end
            if (cfg_addr == AW'(CLKSEL_AD)) clk_sel_pt <= cfg_data[0];
        end
    end

    // R11
    pt_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_addr < AW'(NPT))) |=> (lit_mask[$past(cfg_addr)] == $past(cfg_data)));

    // R11
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(lit_mask) && $stable(ocfg) && $stable(clk_sel_pt)));

endmodule

// File: rtl/ptl_and_array.sv
// Programmable AND array. Builds the true/complement literal set from the
// inputs and forms every product term from its literal mask. An empty mask
// gives a term of 0. Purely combinational.
module ptl_and_array
    import ptl_pkg::*;
(
    input  logic [NIN-1:0]            lin,
    input  logic [NPT-1:0][NLIT-1:0]  lit_mask,
    output logic [NPT-1:0]            pt
);

    logic [NLIT-1:0] lits;

    // Interleave each input with its complement.
    for (genvar i = 0; i < NIN; i++) begin : g_lit
        assign lits[2*i]   = lin[i];
        assign lits[2*i+1] = ~lin[i];
    end

    // One AND gate per product term; unselected literals read as 1.
    for (genvar j = 0; j < NPT; j++) begin : g_term
        assign pt[j] = (|lit_mask[j]) & (&(lits | ~lit_mask[j]));
    end

endmodule

// File: rtl/ptl_out_cell.sv
// One output slice: narrow four-term path, wide masked sum with optional
// XOR against its own XOR term, D register with clear and capture enable,
// register bypass select and final polarity. IDX fixes which shared terms
// form the narrow path and which one is the XOR term.
module ptl_out_cell
    import ptl_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSUM-1:0] sum_pt,
    input  ocfg_t           cfg,
    input  logic            cap_en,
    input  logic            pt_rst,
    output logic            dout,
    output logic            f_o,
    output logic            q_o
);

    localparam int BYP_LO = IDX * NBYP;
    localparam int XT     = XOR_BASE + IDX;
    localparam logic [NSUM-1:0] XT_MASK = {{(NSUM-1){1'b0}}, 1'b1} << XT;

    logic [NSUM-1:0] sel;
    logic            narrow;
    logic            wide;
    logic            f;
    logic            q;

    // Logic value of this output before the register.
    always_comb begin
        sel    = sum_pt & cfg.mask;
        narrow = |sum_pt[BYP_LO +: NBYP];
        if (cfg.xor_en) wide = (|(sel & ~XT_MASK)) ^ sum_pt[XT];
        else            wide = |sel;
        f = cfg.bypass ? narrow : wide;
    end

    // Output register: global clear first, then term clear, then capture.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= 1'b0;
        else if (pt_rst) q <= 1'b0;
        else if (cap_en) q <= f;
    end

    assign dout = (cfg.reg_sel ? q : f) ^ cfg.invert;
    assign f_o  = f;
    assign q_o  = q;

    // R6
    capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && !pt_rst) |=> (q == $past(f)));

    // R9
    no_capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en && !pt_rst) |=> $stable(q));

    // R8
    term_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pt_rst |=> (q == 1'b0));

endmodule

// File: rtl/ptl_block.sv
// Top of the product-term logic cell. Ties the configuration store, the
// AND array and four output slices together and derives the register
// capture enable from the chosen clock source. The term clock is sampled on
// clk, so it must change slower than clk.
module ptl_block
    import ptl_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [AW-1:0]  cfg_addr,
    input  logic [DW-1:0]  cfg_data,
    input  logic [NIN-1:0] lin,
    output logic [NOUT-1:0] dout,
    output logic           oe_out
);

    logic [NPT-1:0][NLIT-1:0] lit_mask;
    ocfg_t [NOUT-1:0]         ocfg;
    logic                     clk_sel_pt;
    logic [NPT-1:0]           pt;
    logic                     clk_term_prev;
    logic                     cap_en;
    logic [NOUT-1:0]          f_all;
    logic [NOUT-1:0]          q_all;

    ptl_cfg_store u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_data   (cfg_data),
        .lit_mask   (lit_mask),
        .ocfg       (ocfg),
        .clk_sel_pt (clk_sel_pt)
    );

    ptl_and_array u_and (
        .lin      (lin),
        .lit_mask (lit_mask),
        .pt       (pt)
    );

    // Remember the clock term at the previous edge for rise detection.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_term_prev <= 1'b0;
        else        clk_term_prev <= pt[PT_CLK];
    end

    // Capture on every edge, or only on a rising clock term.
    always_comb begin
        cap_en = clk_sel_pt ? (pt[PT_CLK] & ~clk_term_prev) : 1'b1;
    end

    for (genvar k = 0; k < NOUT; k++) begin : g_out
        ptl_out_cell #(.IDX(k)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .sum_pt (pt[NSUM-1:0]),
            .cfg    (ocfg[k]),
            .cap_en (cap_en),
            .pt_rst (pt[PT_RST]),
            .dout   (dout[k]),
            .f_o    (f_all[k]),
            .q_o    (q_all[k])
        );
    end

    assign oe_out = pt[PT_OE];

    // R9
    term_clock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel_pt && $rose(pt[PT_CLK]) && !pt[PT_RST]) |=> (q_all == $past(f_all)));

    // R9
    term_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel_pt && !pt[PT_CLK] && !pt[PT_RST]) |=> $stable(q_all));

endmodule

// File: tb/sim_ptl_block.sv
// Bench for ptl_block: a hand-computed vector table, directed corner
// cases, then random configurations checked against a bench model.
module sim_ptl_block;
    import ptl_pkg::*;

    localparam int CLK_P = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [AW-1:0]   cfg_addr = '0;
    logic [DW-1:0]   cfg_data = '0;
    logic [NIN-1:0]  lin = '0;
    logic [NOUT-1:0] dout;
    logic            oe_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [DW-1:0]   m_lit [NPT];
    logic [OCW-1:0]  m_oc  [NOUT];
    logic [NOUT-1:0] m_q = '0;

    // {lin, oe_out, dout[3:0]} for configuration A
    localparam logic [22:0] TBL [10] = '{
        {18'h00000, 5'b00000},
        {18'h00001, 5'b00001},
        {18'h00006, 5'b00001},
        {18'h00008, 5'b00010},
        {18'h00038, 5'b00000},
        {18'h00048, 5'b00110},
        {18'h200C0, 5'b10000},
        {18'h00102, 5'b01000},
        {18'h00700, 5'b01000},
        {18'h3FFFF, 5'b11001}
    };

    always #(CLK_P/2) clk = ~clk;

    ptl_block u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .lin      (lin),
        .dout     (dout),
        .oe_out   (oe_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AW'(a); cfg_data = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        if (a < NPT) m_lit[a] = d;
        else if (a >= OCFG_BASE && a < OCFG_BASE + NOUT) m_oc[a - OCFG_BASE] = d[OCW-1:0];
    endtask

    function automatic logic m_pt(input int j, input logic [NIN-1:0] x);
        if (m_lit[j] == '0) return 1'b0;
        for (int i = 0; i < NIN; i++) begin
            if (m_lit[j][2*i] && !x[i]) return 1'b0;
            if (m_lit[j][2*i+1] && x[i]) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic logic m_f(input int k, input logic [NIN-1:0] x);
        logic acc;
        if (m_oc[k][NSUM]) begin
            acc = 1'b0;
            for (int t = 0; t < NBYP; t++) acc |= m_pt(k*NBYP + t, x);
            return acc;
        end
        acc = 1'b0;
        for (int t = 0; t < NSUM; t++) begin
            if (m_oc[k][t] && !(m_oc[k][NSUM+1] && t == XOR_BASE + k)) acc |= m_pt(t, x);
        end
        if (m_oc[k][NSUM+1]) acc ^= m_pt(XOR_BASE + k, x);
        return acc;
    endfunction

    // Drive one input vector, optionally check all outputs, track registers.
    task automatic step(input logic [NIN-1:0] x, input bit do_chk);
        logic [NOUT-1:0] e;
        logic [NOUT-1:0] nxt;
        @(negedge clk);
        lin = x; #1;
        for (int k = 0; k < NOUT; k++) begin
            e[k] = (m_oc[k][NSUM+2] ? m_q[k] : m_f(k, x)) ^ m_oc[k][NSUM+3];
            nxt[k] = m_f(k, x);
        end
        if (do_chk) chk("R1 R2 R3 R4 R5 R6 R10 random", {3'b0, oe_out, dout}, {3'b0, m_pt(PT_OE, x), e});
        @(posedge clk);
        m_q = nxt;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int j = 0; j < NPT; j++) m_lit[j] = '0;
        for (int k = 0; k < NOUT; k++) m_oc[k] = '0;
        repeat (2) @(posedge clk);
        // configuration A
        for (int j = 0; j < NPT; j++) wr(j, '0);
        wr(0,  36'h1);
        wr(1,  36'h14);
        wr(4,  36'h80);
        wr(5,  36'h500);
        wr(6,  36'h1000);
        wr(18, 36'h4000);
        wr(8,  36'h90000);
        wr(19, 36'h100000);
        wr(PT_OE, 36'h4_0000_0000);
        wr(OCFG_BASE + 0, 36'h10_0000);
        wr(OCFG_BASE + 1, 36'h80_0030);
        wr(OCFG_BASE + 2, 36'h24_0040);
        wr(OCFG_BASE + 3, 36'h08_0100);
        wr(CLKSEL_AD, 36'h0);
        @(negedge clk); rst_n = 1'b1;

        // R1 R2 R3 R4 R5 R10: vector table
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            lin = TBL[i][22:5]; #1;
            chk("R1 R2 R3 R4 R5 R10 table", {3'b0, oe_out, dout}, {3'b0, TBL[i][4:0]});
        end

        // R2: mask ignored in bypass (PT4 active, bypass terms all 0)
        wr(OCFG_BASE + 0, 36'h10_0010);
        @(negedge clk); lin = '0; #1;
        chk("R2 bypass ignores mask", {7'b0, dout[0]}, 8'h0);
        // R3: same mask through the wide path
        wr(OCFG_BASE + 0, 36'h00_0010);
        #1 chk("R3 wide path sum", {7'b0, dout[0]}, 8'h1);

        // R6 R7: registered outputs, then global reset state
        wr(OCFG_BASE + 0, 36'h50_0000);
        wr(OCFG_BASE + 1, 36'hC0_0030);
        @(negedge clk); lin = 18'h1;
        @(posedge clk); #1;
        chk("R6 registered load", {6'b0, dout[1:0]}, 8'h1);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R7 reset state with polarity", {6'b0, dout[1:0]}, 8'h2);
        @(negedge clk); rst_n = 1'b1; #1;
        chk("R6 no change before edge", {7'b0, dout[0]}, 8'h0);
        @(posedge clk); #1;
        chk("R6 one-edge latency", {6'b0, dout[1:0]}, 8'h1);

        // R8: term 20 (= in16) clears registers instead of loading
        wr(PT_RST, 36'h1_0000_0000);
        @(negedge clk); lin = 18'h10001;
        @(posedge clk); #1;
        chk("R8 term clear", {6'b0, dout[1:0]}, 8'h2);
        @(negedge clk); lin = 18'h00001;
        @(posedge clk); #1;
        chk("R8 clear released", {6'b0, dout[1:0]}, 8'h1);

        // R9: term 21 (= in15) as register clock
        wr(PT_RST, '0);
        wr(PT_CLK, 36'h4000_0000);
        wr(CLKSEL_AD, 36'h1);
        @(negedge clk); lin = 18'h00000;
        @(posedge clk); #1;
        chk("R9 clock term low holds", {7'b0, dout[0]}, 8'h1);
        @(negedge clk); lin = 18'h08000;
        @(posedge clk); #1;
        chk("R9 rising clock term loads", {7'b0, dout[0]}, 8'h0);
        @(negedge clk); lin = 18'h08001;
        @(posedge clk); #1;
        chk("R9 clock term held high holds", {7'b0, dout[0]}, 8'h0);
        @(negedge clk); lin = 18'h00001;
        @(posedge clk); #1;
        chk("R9 falling clock term holds", {7'b0, dout[0]}, 8'h0);
        @(negedge clk); lin = 18'h08001;
        @(posedge clk); #1;
        chk("R9 second rise loads", {7'b0, dout[0]}, 8'h1);
        wr(CLKSEL_AD, 36'h0);
        wr(PT_CLK, '0);

        // R11: unstrobed write leaves output 0 mode untouched
        @(negedge clk); lin = 18'h1;
        cfg_we = 1'b0; cfg_addr = AW'(OCFG_BASE); cfg_data = '0;
        @(posedge clk); #1;
        chk("R11 write ignored without strobe", {7'b0, dout[0]}, 8'h1);
        wr(OCFG_BASE + 0, '0);
        chk("R11 strobed write takes effect", {7'b0, dout[0]}, 8'h0);

        // random configurations against the bench model
        for (int c = 0; c < 30; c++) begin
            for (int j = 0; j < NPT; j++) begin
                logic [DW-1:0] pm;
                pm = (DW'(1) << ($urandom % DW)) | (DW'(1) << ($urandom % DW));
                if ($urandom % 4 == 0) pm = DW'(1) << ($urandom % DW);
                if (j == PT_RST || j == PT_CLK) pm = '0;
                wr(j, pm);
            end
            for (int k = 0; k < NOUT; k++) wr(OCFG_BASE + k, DW'($urandom & 32'hFF_FFFF));
            step(NIN'($urandom), 1'b0);
            for (int v = 0; v < 6; v++) step(NIN'($urandom), 1'b1);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule